// File: doc/BRIEF.md
# Strip-Plane Fold Coincidence Logic

This block sits behind the discriminators of one pickup plane of 32 strips. Each strip hit is held open for a programmable number of clock cycles, so that hits arriving at slightly different times can still coincide. The 32 held strips are folded into eight interleaved groups: strip i feeds group i mod 8. The block then reports whether one, two, three or four neighbouring groups are active at the same time. Neighbours are counted around a ring, so the last group is adjacent to the first.

Alongside the fold flags, the block gives an unclocked timing line. This line is the OR of the raw, unstretched strip hits, and a time-to-digital converter uses it as its stop. The fold flags are levels: they stay high for as long as the coincidence lasts. A later cross-layer stage consumes them.

Top module: `strip_fold_coinc`

## Requirements
- R1: Strip index i (0-based) belongs to group i mod NGROUP. A hit on any of the four strips of a group makes that group active.
- R2: fold[0] is high whenever at least one group is active.
- R3: fold[1] is high whenever two ring-adjacent groups are both active. Groups 7 and 0 count as adjacent.
- R4: fold[2] is high whenever three consecutive groups around the ring are all active. This includes the runs 6,7,0 and 7,0,1.
- R5: fold[3] is high whenever four consecutive groups around the ring are all active, with the same wraparound.
- R6: A hit sampled at a rising clock edge keeps its strip active for exactly STRETCH cycles after that edge. The strip then drops unless it is hit again.
- R7: A new hit on a strip that is already active restarts its window of STRETCH cycles from the new edge.
- R8: tdc_stop is the combinational OR of all hit inputs. It has no clock latency.
- R9: While rst_n is low, every window is cleared and all fold flags are low.
- R10: The fold flags are levels. A coincidence that is refreshed on every cycle keeps its flag high on every cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the hit windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | NSTRIP | Discriminated strip hit pulses |
| fold | output | NFOLD | Bit m is high when m+1 ring-adjacent groups are active |
| tdc_stop | output | 1 | Unclocked OR of all strip hits |

## Verification
The bench builds the block with STRETCH=2 and the default 32 strips in 8 groups. The short window lets the bench apply every one of the 256 group patterns and watch each one rise and expire within three cycles. The two-cycle window also makes staggered hits on neighbouring groups practical. Such hits overlap for exactly one cycle, so the bench can tell whether the coincidence is formed from the held windows or from the raw pulses. Each group is driven through a random subset of its four strips, which exercises every strip-to-group mapping, including the wraparound between group 7 and group 0.

// File: rtl/strip_fold_coinc.sv
module strip_fold_coinc #(
  parameter int NSTRIP  = 32,
  parameter int NGROUP  = 8,
  parameter int NFOLD   = 4,
  parameter int STRETCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSTRIP-1:0] hit,
  output logic [NFOLD-1:0]  fold,
  output logic              tdc_stop
);

  localparam int NPER = NSTRIP / NGROUP;
  localparam int CW   = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH);

  logic [NSTRIP-1:0] held;
  logic [NGROUP-1:0] grp;

  for (genvar s = 0; s < NSTRIP; s++) begin : g_strip
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (hit[s])    cnt <= LOAD;
      else if (cnt != 0)  cnt <= cnt - 1'b1;
    end
    assign held[s] = |cnt;
  end

  always_comb begin
    grp = '0;
    for (int g = 0; g < NGROUP; g++)
      for (int j = 0; j < NPER; j++)
        grp[g] = grp[g] | held[g + j*NGROUP];
  end

  function automatic logic ring_run(input logic [NGROUP-1:0] v, input int len);
    logic any, all;
    any = 1'b0;
    for (int k = 0; k < NGROUP; k++) begin
      all = 1'b1;
      for (int j = 0; j < len; j++)
        all = all & v[(k + j) % NGROUP];
      any = any | all;
    end
    return any;
  endfunction

  for (genvar m = 0; m < NFOLD; m++) begin : g_fold
    assign fold[m] = ring_run(grp, m + 1);
  end

  assign tdc_stop = |hit;

  // R9
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> fold == '0);

  // R8
  stop_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tdc_stop |=> fold[0]);

  // R6
  drop_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fold[0]) |-> $past(hit) == '0);

  // R3
  pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold[1] |-> $countones(grp) >= 2);

  for (genvar m = 1; m < NFOLD; m++) begin : g_nest
    // R4 R5
    fold_nested_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fold[m] |-> fold[m-1]);
  end

endmodule

// File: tb/strip_fold_coinc_tb.sv
module strip_fold_coinc_tb;
  localparam int NS = 32, NG = 8, NF = 4, ST = 2;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] hit = '0;
  logic [NF-1:0] fold;
  logic tdc_stop;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  strip_fold_coinc #(.NSTRIP(NS), .NGROUP(NG), .NFOLD(NF), .STRETCH(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit(hit), .fold(fold), .tdc_stop(tdc_stop));

  function automatic logic [NF-1:0] exp_fold(input logic [NG-1:0] p);
    logic [NF-1:0] r;
    for (int m = 0; m < NF; m++) begin
      r[m] = 1'b0;
      for (int k = 0; k < NG; k++) begin
        logic a;
        a = 1'b1;
        for (int j = 0; j <= m; j++) a = a & p[(k + j) % NG];
        r[m] = r[m] | a;
      end
    end
    return r;
  endfunction

  function automatic logic [NS-1:0] spread(input logic [NG-1:0] p);
    logic [NS-1:0] h = '0;
    for (int g = 0; g < NG; g++)
      if (p[g]) begin
        logic [3:0] pick;
        pick = 4'($urandom_range(1, 15));
        for (int j = 0; j < 4; j++) h[g + j*NG] = pick[j];
      end
    return h;
  endfunction

  task automatic chk(input logic [NF-1:0] act, input logic [NF-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_pattern(input logic [NG-1:0] p);
    @(negedge clk) hit = spread(p);
    #1 chk({3'b0, tdc_stop}, {3'b0, |p}, "R8 R1 tdc_stop");
    @(negedge clk) hit = '0;
    chk(fold, exp_fold(p), "R1 R2 R3 R4 R5 fold after edge");
    @(negedge clk) chk(fold, exp_fold(p), "R6 window held");
    @(negedge clk) chk(fold, '0, "R6 window expired");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(fold, '0, "R9 reset state");
    hit = '1;
    @(negedge clk) chk(fold, '0, "R9 hits ignored in reset");
    hit = '0;
    rst_n = 1;
    @(negedge clk);

    for (int p = 0; p < 256; p++) run_pattern(8'(p));

    // R3 wraparound pair: strip 7 (group 7) and strip 8 (group 0)
    @(negedge clk) hit = '0; hit[7] = 1; hit[8] = 1;
    @(negedge clk) hit = '0; chk(fold, 4'b0011, "R3 wrap pair 7-0");
    repeat (2) @(negedge clk);

    // R7 retrigger
    @(negedge clk) hit = '0; hit[3] = 1;
    @(negedge clk) chk(fold, 4'b0001, "R7 first hit");
    @(negedge clk) hit = '0; chk(fold, 4'b0001, "R7 retriggered");
    @(negedge clk) chk(fold, 4'b0001, "R7 window restarted");
    @(negedge clk) chk(fold, 4'b0000, "R7 window ends");

    // R6 staggered neighbours overlap for one cycle
    @(negedge clk) hit = '0; hit[0] = 1;
    @(negedge clk) hit = '0; hit[1] = 1; chk(fold, 4'b0001, "R6 one group");
    @(negedge clk) hit = '0; chk(fold, 4'b0011, "R6 overlap gives pair");
    @(negedge clk) chk(fold, 4'b0001, "R6 first window gone");
    @(negedge clk) chk(fold, 4'b0000, "R6 all gone");

    // R10 level: held triple with wrap 7,0,1
    @(negedge clk) hit = '0; hit[15] = 1; hit[16] = 1; hit[25] = 1;
    for (int c = 0; c < 6; c++) @(negedge clk) chk(fold, 4'b0111, "R10 level held");
    hit = '0;
    repeat (3) @(negedge clk);

    for (int n = 0; n < 200; n++) begin
      logic [NS-1:0] h;
      logic [NG-1:0] p;
      h = {$urandom, $urandom} >> ($urandom_range(0, 3) * 8);
      p = '0;
      for (int i = 0; i < NS; i++) if (h[i]) p[i % NG] = 1'b1;
      @(negedge clk) hit = h;
      @(negedge clk) hit = '0; chk(fold, exp_fold(p), "R1 R5 random strips");
      repeat (2) @(negedge clk);
    end

    // R9 reset in mid-window
    @(negedge clk) hit = '1;
    @(negedge clk) hit = '0; rst_n = 0;
    #1 chk(fold, '0, "R9 async clear");
    @(negedge clk) rst_n = 1;
    @(negedge clk) chk(fold, '0, "R9 stays clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule